// File: doc/BRIEF.md
# SPI DMA Request and Frame Packing Controller

This block sits between a DMA engine and the frame buffers of an SPI peripheral. It raises separate transmit and receive DMA request lines from buffer-room and data-available conditions. Each DMA access moves one 16-bit word through the data port. When the access is 16 bits wide and the SPI frame is 8 bits or narrower, one word carries two frames. Otherwise one word carries one frame.

When packing is active and a transfer has an odd number of frames, a per-direction last-transfer control makes the final access carry a single frame in the low byte. A frame counter, loaded from the programmed transfer length while the peripheral is disabled, finds that final access. The block also reports receive overrun, a coarse transmit fill level and a busy flag. Software uses these to shut down in order: it waits for an empty transmit buffer, then for busy to clear.

Deasserting the peripheral enable empties both buffers, clears the overrun flag, reloads both frame counters and withdraws any pending request. The next transfer therefore starts on a fresh byte pairing.

Top module: `spi_dpk_top`

## Requirements
- R1: `tx_req` is high exactly when `en` and `tx_dma_en` are high and the transmit buffer (4 bytes) has room. A frame costs 1 byte when `frame_bits` <= 8 and 2 bytes otherwise. In packed mode room means at least 2 free bytes. Otherwise it means at least one frame's cost free. A write is taken only while this holds.
- R2: `rx_req` is high exactly when `en` and `rx_dma_en` are high and data is available. In packed mode that means two buffered frames, or one frame when R10 applies. Otherwise it means one buffered frame.
- R3: Each request line depends only on its own DMA enable. With `rx_dma_en` low, `rx_req` stays low even while frames are buffered. With `tx_dma_en` low, `tx_req` stays low.
- R4: A frame pushed by the shift side while the receive buffer lacks room for it is dropped. It sets `ovr`, which stays set until `en` goes low.
- R5: Packed mode is active exactly when `dma_wide` = 1 and `frame_bits` <= 8. With `dma_wide` = 1 and `frame_bits` = 12, a write enqueues one frame.
- R6: In packed mode a write enqueues `dma_wdata[7:0]` as the first frame and `dma_wdata[15:8]` as the second. Each frame is presented zero-extended on `sh_tx_data`, in that order.
- R7: When not packed, a write enqueues all 16 bits of `dma_wdata` as one frame. A read returns one whole buffered frame.
- R8: In packed mode a read returns the older frame in `dma_rdata[7:0]` and the newer one in `dma_rdata[15:8]`, and removes both.
- R9: With `last_tx_odd` = 1 and one transmit frame left in the count, a packed write enqueues only its low byte.
- R10: With `last_rx_odd` = 1 and one receive frame left in the count, a single buffered frame raises `rx_req`. The read returns `{8'h00, frame}` and removes one frame.
- R11: `tx_lvl` encodes transmit buffer bytes: 0 gives 2'b00, 1 gives 2'b01, 2 gives 2'b10, 3 or 4 gives 2'b11.
- R12: `busy` is high when `en` is high and either the transmit buffer holds data or `sh_active` is high.
- R13: While `en` is low, both buffers are emptied, `ovr` is cleared and both frame counters are loaded from `frame_total`. No data from before survives re-enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Peripheral enable; low flushes and reloads |
| tx_dma_en | input | 1 | Transmit DMA enable |
| rx_dma_en | input | 1 | Receive DMA enable |
| dma_wide | input | 1 | DMA access width is 16 bits |
| frame_bits | input | 5 | SPI frame width in bits (4 to 16) |
| frame_total | input | 16 | Frames in the transfer, per direction |
| last_tx_odd | input | 1 | Transmit last access carries one frame |
| last_rx_odd | input | 1 | Receive last access carries one frame |
| dma_wr | input | 1 | DMA write strobe to the data port |
| dma_wdata | input | 16 | DMA write data |
| dma_rd | input | 1 | DMA read strobe from the data port |
| dma_rdata | output | 16 | DMA read data |
| tx_req | output | 1 | Transmit DMA request |
| rx_req | output | 1 | Receive DMA request |
| sh_tx_pop | input | 1 | Shift engine takes the head transmit frame |
| sh_tx_data | output | 16 | Head transmit frame |
| sh_tx_valid | output | 1 | Transmit buffer holds a frame |
| sh_rx_push | input | 1 | Shift engine delivers a received frame |
| sh_rx_data | input | 16 | Received frame |
| sh_active | input | 1 | Shift engine is mid-frame |
| ovr | output | 1 | Receive overrun, sticky |
| tx_lvl | output | 2 | Transmit fill level code |
| busy | output | 1 | Transfer still in progress |

## Verification
Transmit is driven packed with 8-bit frames, unpacked at 16-bit width with 12-bit frames, and unpacked with an 8-bit access. These show whether the pack decision keys on both width and frame size and whether byte order is kept. An odd three-frame transfer on each side tells the last-access single-frame path from normal pairing. A receive-only run with the receive DMA disabled separates request gating from buffering and drives the buffer past capacity for overrun. A disable between runs, followed by fresh data, shows that old bytes and the overrun flag do not carry over.

// File: rtl/spi_dpk_pkg.sv
package spi_dpk_pkg;

  // Fill-level code from byte occupancy and capacity.
  function automatic logic [1:0] lvl_code(input int unsigned bytes, input int unsigned cap);
    if (bytes == 0)            return 2'b00;
    else if (bytes * 4 <= cap) return 2'b01;
    else if (bytes * 2 <= cap) return 2'b10;
    else                       return 2'b11;
  endfunction

  // Frames moved by one DMA access.
  function automatic logic [1:0] frames_per_access(input logic packed_mode, input logic single);
    return (packed_mode && !single) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/spi_dpk_fifo.sv
module spi_dpk_fifo #(
  parameter int DW    = 16,
  parameter int SLOTS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic [1:0]                  push_n,
  input  logic [DW-1:0]               push_d0,
  input  logic [DW-1:0]               push_d1,
  input  logic [1:0]                  pop_n,
  output logic [DW-1:0]               head0,
  output logic [DW-1:0]               head1,
  output logic [$clog2(SLOTS+1)-1:0]  cnt
);
  localparam int PW = $clog2(SLOTS);
  localparam int CW = $clog2(SLOTS+1);

  logic [DW-1:0] mem_q [SLOTS];
  logic [DW-1:0] mem_d [SLOTS];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    mem_d = mem_q;
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_n != 2'd0) mem_d[wp_q] = push_d0;
      if (push_n == 2'd2) mem_d[PW'(wp_q + PW'(1))] = push_d1;
      wp_d  = PW'(wp_q + PW'(push_n));
      rp_d  = PW'(rp_q + PW'(pop_n));
      cnt_d = CW'(cnt_q + CW'(push_n) - CW'(pop_n));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    mem_q <= mem_d;
  end

  assign head0 = mem_q[rp_q];
  assign head1 = mem_q[PW'(rp_q + PW'(1))];
  assign cnt   = cnt_q;

  // R4: the controller never overfills the buffer
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SLOTS))
    else $error("buffer count above capacity");

  // R8: never remove more frames than are held
  p_pop_le_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> CW'(pop_n) <= cnt_q)
    else $error("pop beyond contents");

endmodule

// File: rtl/spi_dpk_left.sv
module spi_dpk_left #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [1:0]    dec,
  output logic [CW-1:0] left
);
  logic [CW-1:0] left_q, left_d;

  always_comb begin
    if (load)                       left_d = load_val;
    else if (CW'(dec) > left_q)     left_d = '0;
    else                            left_d = left_q - CW'(dec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign left = left_q;

  // R9: the count moves only on a load or a consumed frame
  p_left_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dec == 2'd0) |=> $stable(left_q))
    else $error("frame count moved without cause");

endmodule

// File: rtl/spi_dpk_top.sv
module spi_dpk_top #(
  parameter int DW         = 16,
  parameter int FIFO_BYTES = 4,
  parameter int CNTW       = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        tx_dma_en,
  input  logic                        rx_dma_en,
  input  logic                        dma_wide,
  input  logic [$clog2(DW+1)-1:0]     frame_bits,
  input  logic [CNTW-1:0]             frame_total,
  input  logic                        last_tx_odd,
  input  logic                        last_rx_odd,
  input  logic                        dma_wr,
  input  logic [DW-1:0]               dma_wdata,
  input  logic                        dma_rd,
  output logic [DW-1:0]               dma_rdata,
  output logic                        tx_req,
  output logic                        rx_req,
  input  logic                        sh_tx_pop,
  output logic [DW-1:0]               sh_tx_data,
  output logic                        sh_tx_valid,
  input  logic                        sh_rx_push,
  input  logic [DW-1:0]               sh_rx_data,
  input  logic                        sh_active,
  output logic                        ovr,
  output logic [1:0]                  tx_lvl,
  output logic                        busy
);
  import spi_dpk_pkg::*;

  localparam int HB  = DW / 2;
  localparam int FBW = $clog2(DW+1);
  localparam int CW  = $clog2(FIFO_BYTES+1);
  localparam int BW  = $clog2(2*FIFO_BYTES+1);
  localparam logic [BW-1:0] CAP_B = BW'(FIFO_BYTES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // mode decode
  logic          packed_mode;
  logic [BW-1:0] cost;
  assign packed_mode = dma_wide && (frame_bits <= FBW'(HB));
  assign cost        = (frame_bits > FBW'(HB)) ? BW'(2) : BW'(1);

  // transmit path
  logic [CW-1:0]   tx_cnt;
  logic [DW-1:0]   tx_h0, tx_h1;
  logic [CNTW-1:0] tx_left;
  logic [BW-1:0]   tx_bytes, tx_free;
  logic            tx_last1, txe, wr_ok;
  logic [1:0]      tx_push_n, tx_pop_n;
  logic [DW-1:0]   tx_d0, tx_d1;

  assign tx_bytes = BW'(tx_cnt) * cost;
  assign tx_free  = CAP_B - tx_bytes;
  assign tx_last1 = last_tx_odd && (tx_left == CNTW'(1));
  assign txe      = packed_mode ? (tx_free >= BW'(2)) : (tx_free >= cost);
  assign wr_ok    = dma_wr && en && txe;

  always_comb begin
    tx_push_n = wr_ok ? frames_per_access(packed_mode, tx_last1) : 2'd0;
    tx_pop_n  = (sh_tx_pop && en && tx_cnt != '0) ? 2'd1 : 2'd0;
    if (packed_mode) begin
      tx_d0 = {{(DW-HB){1'b0}}, dma_wdata[HB-1:0]};
      tx_d1 = {{(DW-HB){1'b0}}, dma_wdata[DW-1:HB]};
    end else begin
      tx_d0 = dma_wdata;
      tx_d1 = '0;
    end
  end

  spi_dpk_fifo #(.DW(DW), .SLOTS(FIFO_BYTES)) u_txf (
    .clk(clk), .rst_n(rst_ni), .flush(!en),
    .push_n(tx_push_n), .push_d0(tx_d0), .push_d1(tx_d1),
    .pop_n(tx_pop_n), .head0(tx_h0), .head1(tx_h1), .cnt(tx_cnt));

  spi_dpk_left #(.CW(CNTW)) u_txl (
    .clk(clk), .rst_n(rst_ni), .load(!en), .load_val(frame_total),
    .dec(tx_push_n), .left(tx_left));

  // receive path
  logic [CW-1:0]   rx_cnt;
  logic [DW-1:0]   rx_h0, rx_h1;
  logic [CNTW-1:0] rx_left;
  logic [BW-1:0]   rx_bytes;
  logic            rx_last1, rxne, rd_ok, rx_room, rx_drop;
  logic [1:0]      rx_push_n, rx_pop_n;

  assign rx_bytes = BW'(rx_cnt) * cost;
  assign rx_room  = (rx_bytes + cost) <= CAP_B;
  assign rx_last1 = last_rx_odd && (rx_left == CNTW'(1));
  assign rxne     = packed_mode ? ((rx_cnt >= CW'(2)) || (rx_last1 && rx_cnt != '0))
                                : (rx_cnt != '0);
  assign rd_ok    = dma_rd && en && rxne;
  assign rx_drop  = sh_rx_push && en && !rx_room;

  always_comb begin
    rx_push_n = (sh_rx_push && en && rx_room) ? 2'd1 : 2'd0;
    rx_pop_n  = rd_ok ? frames_per_access(packed_mode, rx_last1) : 2'd0;
    if (!packed_mode)          dma_rdata = rx_h0;
    else if (rx_pop_n == 2'd1 || rx_last1)
                               dma_rdata = {{(DW-HB){1'b0}}, rx_h0[HB-1:0]};
    else                       dma_rdata = {rx_h1[HB-1:0], rx_h0[HB-1:0]};
  end

  spi_dpk_fifo #(.DW(DW), .SLOTS(FIFO_BYTES)) u_rxf (
    .clk(clk), .rst_n(rst_ni), .flush(!en),
    .push_n(rx_push_n), .push_d0(sh_rx_data), .push_d1('0),
    .pop_n(rx_pop_n), .head0(rx_h0), .head1(rx_h1), .cnt(rx_cnt));

  spi_dpk_left #(.CW(CNTW)) u_rxl (
    .clk(clk), .rst_n(rst_ni), .load(!en), .load_val(frame_total),
    .dec(rx_pop_n), .left(rx_left));

  // overrun flag
  logic ovr_q, ovr_d;
  assign ovr_d = en ? (ovr_q || rx_drop) : 1'b0;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b0;
    else         ovr_q <= ovr_d;
  end

  // outputs
  assign tx_req      = en && tx_dma_en && txe;
  assign rx_req      = en && rx_dma_en && rxne;
  assign sh_tx_data  = tx_h0;
  assign sh_tx_valid = tx_cnt != '0;
  assign ovr         = ovr_q;
  assign tx_lvl      = lvl_code(int'(tx_bytes), FIFO_BYTES);
  assign busy        = en && (sh_tx_valid || sh_active);

  // R1: a packed request implies two free bytes
  p_txroom_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_req && packed_mode) |-> tx_lvl <= 2'b10)
    else $error("packed tx request without room");

  // R2: a receive request implies buffered data
  p_rxdata_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    rx_req |-> rx_cnt != '0)
    else $error("rx request with empty buffer");

  // R4: overrun stays set while enabled
  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && ovr) |=> ovr)
    else $error("overrun cleared while enabled");

  // R13: disabling empties both sides and clears overrun
  p_flush_r13: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |=> (tx_cnt == '0 && rx_cnt == '0 && !ovr))
    else $error("disable did not flush");

  // R12: buffered transmit data keeps busy high
  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && tx_lvl != 2'b00) |-> busy)
    else $error("busy low with data queued");

endmodule

// File: tb/sim_spi_dpk_top.sv
module sim_spi_dpk_top;
  logic        clk = 1'b0;
  logic        rst_n, en, tx_dma_en, rx_dma_en, dma_wide;
  logic [4:0]  frame_bits;
  logic [15:0] frame_total;
  logic        last_tx_odd, last_rx_odd, dma_wr, dma_rd;
  logic [15:0] dma_wdata, dma_rdata, sh_tx_data, sh_rx_data;
  logic        tx_req, rx_req, sh_tx_pop, sh_tx_valid, sh_rx_push, sh_active;
  logic        ovr, busy;
  logic [1:0]  tx_lvl;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  spi_dpk_top u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .dma_wide(dma_wide), .frame_bits(frame_bits), .frame_total(frame_total),
    .last_tx_odd(last_tx_odd), .last_rx_odd(last_rx_odd),
    .dma_wr(dma_wr), .dma_wdata(dma_wdata), .dma_rd(dma_rd), .dma_rdata(dma_rdata),
    .tx_req(tx_req), .rx_req(rx_req), .sh_tx_pop(sh_tx_pop), .sh_tx_data(sh_tx_data),
    .sh_tx_valid(sh_tx_valid), .sh_rx_push(sh_rx_push), .sh_rx_data(sh_rx_data),
    .sh_active(sh_active), .ovr(ovr), .tx_lvl(tx_lvl), .busy(busy));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic restart(input logic wide, input logic [4:0] fb, input logic [15:0] tot,
                         input logic txo, input logic rxo, input logic txd, input logic rxd);
    en = 1'b0; dma_wide = wide; frame_bits = fb; frame_total = tot;
    last_tx_odd = txo; last_rx_odd = rxo; tx_dma_en = txd; rx_dma_en = rxd;
    step(); step();
    en = 1'b1;
    step();
  endtask

  task automatic wr(input logic [15:0] d);
    dma_wdata = d; dma_wr = 1'b1; step(); dma_wr = 1'b0;
  endtask

  task automatic rd();
    dma_rd = 1'b1; step(); dma_rd = 1'b0;
  endtask

  task automatic push(input logic [15:0] d);
    sh_rx_data = d; sh_rx_push = 1'b1; step(); sh_rx_push = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input logic [15:0] exp);
    chk(tag, {31'd0, sh_tx_valid}, 32'd1);
    chk(tag, {16'd0, sh_tx_data}, {16'd0, exp});
    sh_tx_pop = 1'b1; step(); sh_tx_pop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 reset busy", {31'd0, busy}, 0);
    chk("R1 reset tx_req", {31'd0, tx_req}, 0);
    chk("R2 reset rx_req", {31'd0, rx_req}, 0);
    chk("R4 reset ovr", {31'd0, ovr}, 0);
    chk("R11 reset lvl", {30'd0, tx_lvl}, 0);
  endtask

  task automatic t_tx_packed();
    restart(1'b1, 5'd8, 16'd4, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R1 empty tx_req", {31'd0, tx_req}, 1);
    wr(16'hB2A1);
    chk("R11 half", {30'd0, tx_lvl}, 32'd2);
    chk("R1 two free", {31'd0, tx_req}, 1);
    wr(16'hD4C3);
    chk("R11 full", {30'd0, tx_lvl}, 32'd3);
    chk("R1 no room", {31'd0, tx_req}, 0);
    chk("R12 busy queued", {31'd0, busy}, 1);
    pop_chk("R6 f0", 16'h00A1);
    pop_chk("R6 f1", 16'h00B2);
    pop_chk("R6 f2", 16'h00C3);
    pop_chk("R6 f3", 16'h00D4);
    chk("R11 empty", {30'd0, tx_lvl}, 0);
    chk("R12 idle", {31'd0, busy}, 0);
    sh_active = 1'b1; #1;
    chk("R12 shifting", {31'd0, busy}, 1);
    sh_active = 1'b0;
  endtask

  task automatic t_tx_unpacked();
    restart(1'b1, 5'd12, 16'd2, 1'b0, 1'b0, 1'b1, 1'b0);
    wr(16'h0ABC);
    chk("R5 wide 12b one frame", {30'd0, tx_lvl}, 32'd2);
    chk("R1 room for 2B", {31'd0, tx_req}, 1);
    wr(16'h0DEF);
    chk("R1 full 12b", {31'd0, tx_req}, 0);
    pop_chk("R7 w0", 16'h0ABC);
    pop_chk("R7 w1", 16'h0DEF);
    restart(1'b0, 5'd8, 16'd2, 1'b0, 1'b0, 1'b1, 1'b0);
    wr(16'h0055);
    chk("R11 quarter", {30'd0, tx_lvl}, 32'd1);
    pop_chk("R7 narrow access", 16'h0055);
  endtask

  task automatic t_tx_odd();
    restart(1'b1, 5'd8, 16'd3, 1'b1, 1'b0, 1'b1, 1'b0);
    wr(16'h2211);
    wr(16'h4433);
    chk("R9 three bytes", {30'd0, tx_lvl}, 32'd3);
    chk("R9 tx_req low", {31'd0, tx_req}, 0);
    pop_chk("R9 f0", 16'h0011);
    pop_chk("R9 f1", 16'h0022);
    pop_chk("R9 f2", 16'h0033);
    chk("R9 high byte dropped", {31'd0, sh_tx_valid}, 0);
  endtask

  task automatic t_rx_packed();
    restart(1'b1, 5'd8, 16'd4, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R3 tx off", {31'd0, tx_req}, 0);
    push(16'h005A);
    chk("R2 one frame", {31'd0, rx_req}, 0);
    push(16'h006B);
    chk("R2 two frames", {31'd0, rx_req}, 1);
    chk("R8 order", {16'd0, dma_rdata}, 32'h6B5A);
    rd();
    chk("R8 both removed", {31'd0, rx_req}, 0);
  endtask

  task automatic t_rx_odd();
    restart(1'b1, 5'd8, 16'd3, 1'b0, 1'b1, 1'b0, 1'b1);
    push(16'h0001);
    push(16'h0002);
    chk("R10 pair", {16'd0, dma_rdata}, 32'h0201);
    rd();
    push(16'h0003);
    chk("R10 single req", {31'd0, rx_req}, 1);
    chk("R10 single data", {16'd0, dma_rdata}, 32'h0003);
    rd();
    chk("R10 single removed", {31'd0, rx_req}, 0);
  endtask

  task automatic t_overrun();
    restart(1'b1, 5'd8, 16'd8, 1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) push(16'(i + 1));
    chk("R4 no ovr at cap", {31'd0, ovr}, 0);
    chk("R3 rx off", {31'd0, rx_req}, 0);
    push(16'h0099);
    chk("R4 ovr set", {31'd0, ovr}, 1);
    step();
    chk("R4 ovr sticky", {31'd0, ovr}, 1);
    wr(16'h0201);
    en = 1'b0; step();
    chk("R13 ovr clear", {31'd0, ovr}, 0);
    chk("R13 tx flushed", {31'd0, sh_tx_valid}, 0);
    chk("R13 lvl", {30'd0, tx_lvl}, 0);
    rx_dma_en = 1'b1; en = 1'b1; step();
    chk("R13 rx empty", {31'd0, rx_req}, 0);
    push(16'h000E);
    push(16'h000F);
    chk("R13 fresh data", {16'd0, dma_rdata}, 32'h0F0E);
  endtask

  task automatic t_rx_unpacked();
    restart(1'b0, 5'd8, 16'd2, 1'b0, 1'b0, 1'b0, 1'b1);
    push(16'h0077);
    chk("R2 unpacked req", {31'd0, rx_req}, 1);
    chk("R7 unpacked read", {16'd0, dma_rdata}, 32'h0077);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; tx_dma_en = 1'b0; rx_dma_en = 1'b0; dma_wide = 1'b1;
    frame_bits = 5'd8; frame_total = 16'd0; last_tx_odd = 1'b0; last_rx_odd = 1'b0;
    dma_wr = 1'b0; dma_rd = 1'b0; dma_wdata = '0; sh_tx_pop = 1'b0;
    sh_rx_push = 1'b0; sh_rx_data = '0; sh_active = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_tx_packed();
    t_tx_unpacked();
    t_tx_odd();
    t_rx_packed();
    t_rx_odd();
    t_overrun();
    t_rx_unpacked();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule